// File: doc/BRIEF.md
# Interprocessor and Interval-Timer Interrupt Register

This block holds one 64-bit control and status word shared by up to four processors, together with one interval-ignore counter per processor. The control word keeps a pending interprocessor-interrupt bit and a pending timer-interrupt bit for each processor. It also keeps an arbitration tag/winner pair and a small plain read/write field. Each of these fields follows its own write rule: clear on one, set on one, set only while empty, or set through a separate request bit.

A shared periodic timer input drives all the ignore counters. On each rising edge every counter steps down by one. A counter that has passed below zero keeps a sticky overflow flag. While that flag is set, every timer edge raises the processor's timer-interrupt bit. Software uses the counters to skip a chosen number of timer ticks, and can later read how many ticks went by. Reads of the control word also return the index of the processor that issued the read.

Top module: `ipt_ctrl`

## Requirements
- R1: After reset the control word, all counters, all overflow flags and both interrupt output vectors are zero.
- R2: A read at word address 0 returns the stored control word ORed with the requester index in bits [1:0]. A read at address 1+i returns counter i as {overflow, count[23:0]} zero-extended. All other addresses read as zero, and so do the control bits outside the fields listed in R3 to R8.
- R3: A write with a 1 in bit 4+i clears timer-interrupt bit 4+i. A write with a 1 in bit 8+i clears interprocessor bit 8+i.
- R4: A write with bit 20 set clears bits [23:16] and sets none of them.
- R5: A write with bit 20 clear ORs the written bits [23:20] into the tag field [23:20].
- R6: With bit 20 clear, the winner field [19:16] takes the written bits only when it is zero after the clear step. Otherwise it keeps its value.
- R7: A written 1 in request bit 12+i sets interprocessor bit 8+i. The request is applied after the clear step, so one write can clear and set the same bit, and the bit ends up set.
- R8: Bits [43:40] take the written value on every write to address 0.
- R9: Output ipi_o[i] follows bit 8+i and output iti_o[i] follows bit 4+i. No register write can set a timer-interrupt bit.
- R10: On each rising edge of tick_in, every count decrements modulo 2^24. The overflow flag sets when a count of zero decrements and then stays set. Falling edges and a held-high input cause no further decrement.
- R11: On a timer edge, any processor whose overflow flag is set after the step gets timer-interrupt bit 4+i set.
- R12: A write to address 1+i loads count i from write bits [23:0] and clears its overflow flag. A timer edge in the same cycle is discarded for that counter.
- R13: When a timer edge sets a timer-interrupt bit in the same cycle that a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address: 0 selects the control word, 1+i selects counter i |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rd_cpu | input | 2 | Index of the processor issuing the access |
| bus_rdata | output | 64 | Combinational read data |
| tick_in | input | 1 | Shared periodic timer input |
| ipi_o | output | 4 | Interprocessor interrupt, one per processor |
| iti_o | output | 4 | Interval-timer interrupt, one per processor |

## Verification
The assertions assume that tick_in is synchronous to clk and low during reset, so that the first edge seen after reset is a genuine low-to-high change. They also assume that the reset is held across at least one clock edge. The bench changes every input on the falling clock edge, holds tick_in low while reset is applied, and raises tick_in for one or more whole cycles. A write and a timer edge coincide only in the test that checks which one wins.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int WORD_W      = 64;
    localparam int CPU_IDX_W   = 2;
    localparam int FLD_W       = 4;

    // bit positions that software and the per-CPU outputs decode
    localparam int ITI_LO      = 4;
    localparam int IPI_LO      = 8;
    localparam int REQ_LO      = 12;
    localparam int WIN_LO      = 16;
    localparam int TAG_LO      = 20;
    localparam int ARB_CLR_BIT = 20;
    localparam int RW_LO       = 40;

    localparam logic [WORD_W-1:0] W1C_MASK = 64'h0000_0000_1000_0FF0;

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } ctl_state_t;

    // bits of the control word that hold state for n processors
    function automatic logic [WORD_W-1:0] keep_mask(int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[ITI_LO+i] = 1'b1;
            m[IPI_LO+i] = 1'b1;
        end
        m[WIN_LO +: FLD_W] = '1;
        m[TAG_LO +: FLD_W] = '1;
        m[RW_LO  +: FLD_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/ipt_rise_det.sv
module ipt_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic rise_o
);
    logic tick_d, tick_q;

    always_comb begin
        tick_d = tick_i;
        rise_o = tick_i & ~tick_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R10

endmodule

// File: rtl/ipt_ign_ctr.sv
module ipt_ign_ctr #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             set_iti_o
);
    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] cnt;
    } ign_state_t;

    ign_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        set_iti_o = 1'b0;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
            st_d.ovf = 1'b0;
        end else if (tick_i) begin
            st_d.cnt  = st_q.cnt - 1'b1;
            st_d.ovf  = st_q.ovf | (st_q.cnt == '0);
            set_iti_o = st_d.ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    AST_LOAD_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (!ovf_o && cnt_o == $past(ld_val_i))); // R12
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ld_i) |=> ovf_o); // R10
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !tick_i) |=> $stable(cnt_o)); // R10

endmodule

// File: rtl/ipt_ctl_reg.sv
module ipt_ctl_reg
    import ipt_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [NCPU-1:0]   tmr_set_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [WORD_W-1:0] KEEP = keep_mask(NCPU);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.word = st_q.word & ~(wdata_i & W1C_MASK);
            if (wdata_i[ARB_CLR_BIT]) begin
                st_d.word[WIN_LO +: 2*FLD_W] = '0;
            end else begin
                st_d.word[TAG_LO +: FLD_W] = st_d.word[TAG_LO +: FLD_W] | wdata_i[TAG_LO +: FLD_W];
                if (st_d.word[WIN_LO +: FLD_W] == '0)
                    st_d.word[WIN_LO +: FLD_W] = wdata_i[WIN_LO +: FLD_W];
            end
            for (int i = 0; i < NCPU; i++) begin
                if (wdata_i[REQ_LO+i]) st_d.word[IPI_LO+i] = 1'b1;
            end
            st_d.word[RW_LO +: FLD_W] = wdata_i[RW_LO +: FLD_W];
        end
        for (int i = 0; i < NCPU; i++) begin
            if (tmr_set_i[i]) st_d.word[ITI_LO+i] = 1'b1;
        end
        st_d.word = st_d.word & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    AST_ITI_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((word_o[ITI_LO +: NCPU] & ~$past(word_o[ITI_LO +: NCPU]) & ~$past(tmr_set_i)) == '0)); // R9
    AST_TIMER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((word_o[ITI_LO +: NCPU] & $past(tmr_set_i)) == $past(tmr_set_i))); // R13
    AST_ARB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[ARB_CLR_BIT]) |=> (word_o[WIN_LO +: 2*FLD_W] == '0)); // R4
    AST_REQ_SETS_IPI: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[REQ_LO]) |=> word_o[IPI_LO]); // R7
    AST_RW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (word_o[RW_LO +: FLD_W] == $past(wdata_i[RW_LO +: FLD_W]))); // R8

endmodule

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
    import ipt_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 24,
    localparam int ADDR_W = $clog2(NCPU + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 bus_we,
    input  logic [CPU_IDX_W-1:0] bus_rd_cpu,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 tick_in,
    output logic [NCPU-1:0]      ipi_o,
    output logic [NCPU-1:0]      iti_o
);
    localparam int PAD_W = WORD_W - CNT_W - 1;

    logic              tick_rise;
    logic [WORD_W-1:0] ctl_word;
    logic              ctl_we;
    logic [NCPU-1:0]   tmr_set;
    logic [NCPU-1:0]   ovf_w;
    logic [CNT_W-1:0]  cnt_w [NCPU];

    assign ctl_we = bus_we && (bus_addr == '0);

    ipt_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_in),
        .rise_o (tick_rise)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_ign
        logic ld;
        assign ld = bus_we && (bus_addr == ADDR_W'(g + 1));
        ipt_ign_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_i      (ld),
            .ld_val_i  (bus_wdata[CNT_W-1:0]),
            .tick_i    (tick_rise),
            .cnt_o     (cnt_w[g]),
            .ovf_o     (ovf_w[g]),
            .set_iti_o (tmr_set[g])
        );
    end

    ipt_ctl_reg #(.NCPU(NCPU)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (ctl_we),
        .wdata_i   (bus_wdata),
        .tmr_set_i (tmr_set),
        .word_o    (ctl_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            bus_rdata = ctl_word | {{(WORD_W-CPU_IDX_W){1'b0}}, bus_rd_cpu};
        end
        for (int i = 0; i < NCPU; i++) begin
            if (bus_addr == ADDR_W'(i + 1))
                bus_rdata = {{PAD_W{1'b0}}, ovf_w[i], cnt_w[i]};
        end
    end

    assign ipi_o = ctl_word[IPI_LO +: NCPU];
    assign iti_o = ctl_word[ITI_LO +: NCPU];

endmodule

// File: tb/tb_ipt_ctrl.sv
module tb_ipt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_rd_cpu = '0;
    logic [63:0] bus_rdata;
    logic        tick_in = 1'b0;
    logic [3:0]  ipi_o, iti_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rd_cpu(bus_rd_cpu), .bus_rdata(bus_rdata),
        .tick_in(tick_in), .ipi_o(ipi_o), .iti_o(iti_o)
    );

    // control-word writes and the expected stored word after each
    localparam logic [63:0] VEC_W [NV] = '{
        64'h0000_0F00_0000_F000, // R7 R8 requests set IPI, RW field loads
        64'h0000_0000_0000_0300, // R3 R8 clear IPI 9:8, RW field replaced
        64'h0000_0000_0050_0000, // R4 clear bit set: nothing is set
        64'h0000_0000_00A3_0000, // R5 R6 tag set, winner empty so loads
        64'h0000_0000_004C_0000, // R5 R6 tag ORs, winner kept
        64'h0000_0000_0010_0000, // R4 arbitration clear
        64'h0000_0000_0000_4C00, // R7 clear and set in one write
        64'h0000_0000_1000_00F0, // R9 timer bits cannot be set by write
        64'h0000_0000_0001_0000  // R6 winner loads when empty
    };
    localparam logic [63:0] VEC_E [NV] = '{
        64'h0000_0F00_0000_0F00,
        64'h0000_0000_0000_0C00,
        64'h0000_0000_0000_0C00,
        64'h0000_0000_00A3_0C00,
        64'h0000_0000_00E3_0C00,
        64'h0000_0000_0000_0C00,
        64'h0000_0000_0000_0400,
        64'h0000_0000_0000_0400,
        64'h0000_0000_0001_0400
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] c, output logic [63:0] d);
        bus_addr = a; bus_rd_cpu = c;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk); tick_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ipi", {60'd0, ipi_o}, 64'd0);
        chk("R1 iti", {60'd0, iti_o}, 64'd0);
        rd(3'd0, 2'd3, r); chk("R1 R2 ctl read with index", r, 64'd3);
        rd(3'd1, 2'd0, r); chk("R1 counter0", r, 64'd0);
        rd(3'd6, 2'd1, r); chk("R2 unmapped", r, 64'd0);

        for (int k = 0; k < NV; k++) begin
            wr(3'd0, VEC_W[k]);
            rd(3'd0, 2'(k % 4), r);
            chk($sformatf("R2 vector %0d read", k), r, VEC_E[k] | 64'(k % 4));
            chk($sformatf("R9 vector %0d ipi", k), {60'd0, ipi_o}, {60'd0, VEC_E[k][11:8]});
            chk($sformatf("R9 vector %0d iti", k), {60'd0, iti_o}, {60'd0, VEC_E[k][7:4]});
        end

        wr(3'd1, 64'd2);
        wr(3'd2, 64'd5);
        wr(3'd3, 64'hFFFF_FFFF_FF00_0000); // R12 only low 24 bits load
        wr(3'd4, 64'h0000_0000_0080_0000);
        rd(3'd3, 2'd0, r); chk("R12 load low bits", r, 64'd0);
        rd(3'd2, 2'd0, r); chk("R12 load value", r, 64'd5);

        tick();
        chk("R11 iti after tick1", {60'd0, iti_o}, 64'h4);
        rd(3'd3, 2'd0, r); chk("R10 wrap sets overflow", r, 64'h1FF_FFFF);
        tick();
        rd(3'd1, 2'd0, r); chk("R10 counter0 at zero", r, 64'd0);
        chk("R11 iti after tick2", {60'd0, iti_o}, 64'h4);
        tick();
        chk("R11 iti after tick3", {60'd0, iti_o}, 64'h5);
        rd(3'd3, 2'd0, r); chk("R10 overflow kept", r, 64'h1FF_FFFD);

        // held high: one decrement only
        @(negedge clk); tick_in = 1'b1;
        repeat (5) @(negedge clk);
        tick_in = 1'b0;
        @(negedge clk);
        rd(3'd2, 2'd0, r); chk("R10 held high single step", r, 64'd1);
        rd(3'd4, 2'd0, r); chk("R10 counter3", r, 64'h7F_FFFC);

        wr(3'd0, 64'h10);
        chk("R3 iti0 cleared", {63'd0, iti_o[0]}, 64'd0);
        tick();
        chk("R11 overflow re-sets iti0", {63'd0, iti_o[0]}, 64'd1);

        wr(3'd1, 64'd10);
        rd(3'd1, 2'd0, r); chk("R12 load clears overflow", r, 64'd10);
        wr(3'd0, 64'h10);
        tick();
        chk("R12 no re-set after load", {63'd0, iti_o[0]}, 64'd0);
        rd(3'd1, 2'd0, r); chk("R10 step after load", r, 64'd9);

        // R13 clear and timer set of iti2 in the same cycle
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 64'h40; tick_in = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_in = 1'b0;
        chk("R13 timer set wins", {63'd0, iti_o[2]}, 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule